// File: doc/BRIEF.md
# Doorbell-Gated Command Sequencer

This block decides when an execution unit may take the next command from a queue of flash commands. Software groups commands into sequences. Each sequence opens with a bus-acquire command and closes with a bus-release command. Software loads one or more sequences and then rings a doorbell. Ringing the doorbell adds a signed 8-bit value to a credit count that the block keeps. Each time the sequencer takes a bus-acquire command, it spends one credit. If no credit is available when a bus-acquire command reaches the head of the queue, the sequencer holds that command and waits until software adds credit.

Commands other than bus-acquire pass through without any credit check. An execution-disable input lets software stop the sequencer once the queue drains. While it is set, the sequencer does not restart when new commands arrive. A watchdog abandons a command that the execution unit fails to finish. It never counts while the sequencer is waiting for credit. An idle output tells software that all execution has finished and the queue is empty.

Top module: `dbell_seq`

## Requirements
- R1: After reset the credit count is 0. `stalled`, `wdog_expire` and `bad_state` are low. `idle` is high while `cmd_valid` is low.
- R2: A cycle with `db_wr` high adds `db_wdata`, read as a signed two's-complement value, to the credit count modulo 2^8. The result shows on `db_count` after the next clock edge. Without a write or a decrement, the count holds.
- R3: Taking a bus-acquire command lowers the count by exactly 1. If a write lands in the same cycle, the new count is count + data - 1.
- R4: A bus-acquire command has opcode `ACQ_OP`, which defaults to 8'h5A. If the signed count is zero or negative when a bus-acquire command is at the head, the command is not taken and `stalled` goes high. Any other opcode is taken whatever the count.
- R5: The stall holds until software writes enough to make the count positive. A write that leaves the count zero or negative keeps the stall. Once the count is positive, the held command is taken and the count drops by one.
- R6: If `exe_dis` is high while the sequencer is idle, no command is taken even when `cmd_valid` is high. A sequence that is already running keeps taking commands until the queue is empty. Once `exe_dis` is low and `cmd_valid` is high, execution resumes.
- R7: `idle` is high only when no command is in flight and `cmd_valid` is low. A command waiting behind `exe_dis` keeps `idle` low.
- R8: A command that stays in execution for `WDOG_LIMIT` cycles (default 16) without `exec_done` raises `wdog_expire` for exactly one cycle, in its WDOG_LIMIT-th cycle. The command is then abandoned. Cycles spent stalled on credit are never counted.
- R9: An illegal state encoding sends the state machine back to idle and sets the sticky `bad_state` output.
- R10: `cmd_ready` is high only when a command is being taken. In that same cycle, `exec_start` pulses and `exec_op` carries the opcode. No further command is taken until `exec_done` arrives or the watchdog expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Queue holds a command at its head |
| cmd_op | input | OP_W | Opcode at the queue head |
| cmd_ready | output | 1 | Head command is taken this cycle |
| exe_dis | input | 1 | Execution-disable control |
| db_wr | input | 1 | Software write strobe for the credit count |
| db_wdata | input | CNT_W | Signed value added to the count |
| db_count | output | CNT_W | Current signed credit count |
| exec_start | output | 1 | Pulse: command handed to the execution unit |
| exec_op | output | OP_W | Opcode handed over with `exec_start` |
| exec_done | input | 1 | Execution unit finished the current command |
| idle | output | 1 | No command in flight and queue empty |
| stalled | output | 1 | Waiting for credit on a bus-acquire command |
| wdog_expire | output | 1 | One-cycle watchdog timeout pulse |
| bad_state | output | 1 | Sticky illegal-state flag |

## Verification
The bench targets the signed boundary of the credit count. It stalls at exactly zero and at minus one, and it adds credit in steps that leave the count non-positive. A design that tests the count without its sign, or that releases the stall on any write, takes the held command too early. The bench also lands a write in the same cycle as a bus-acquire command is taken; a design that lets one of the two updates overwrite the other leaves a count that is one off or lost. Further tests hold the sequencer stalled for longer than the watchdog limit, which catches a watchdog that counts while stalled. Another toggles `exe_dis` around a running sequence, which catches a design that cuts the sequence short or restarts from idle while disabled.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   // Three-bit binary encoding; codes 4..7 are illegal and trapped.
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_STALL = 3'd2,
      ST_EXEC  = 3'd3
   } seq_state_e;
endpackage

// File: rtl/dbs_credit.sv
module dbs_credit #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             count_pos
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] add_v;
   logic [CNT_W-1:0] sub_v;

   assign add_v = wr  ? wdata : ZERO;
   assign sub_v = dec ? ONE   : ZERO;

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= ZERO;
      else        count_q <= count_q + add_v - sub_v;
   end

   assign count     = count_q;
   assign count_pos = !count_q[CNT_W-1] && (|count_q);

   AST_CREDIT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !wr) |=> (count_q == $past(count_q) - ONE)); // R3
   AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !wr) |=> $stable(count_q)); // R2
endmodule

// File: rtl/dbs_wdog.sv
module dbs_wdog #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic done,
   output logic expire
);
   generate
      if (LIMIT > 0) begin : g_on
         localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !busy) cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
         end

         assign expire = busy && !done && (cnt_q == LAST);

         AST_WDOG_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |=> (cnt_q == '0)); // R8
      end else begin : g_off
         assign expire = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dbs_fsm.sv
module dbs_fsm
   import dbs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic is_acq,
   input  logic count_pos,
   input  logic exe_dis,
   input  logic exec_done,
   input  logic wdog_expire,
   output logic cmd_ready,
   output logic stalled,
   output logic exec_busy,
   output logic idle_st,
   output logic bad_state
);
   seq_state_e state_q, state_d;
   logic       bad_q, bad_d;
   logic       legal;

   always_comb begin
      state_d   = state_q;
      bad_d     = bad_q;
      cmd_ready = 1'b0;
      legal     = 1'b1;
      case (state_q)
         ST_IDLE:  if (cmd_valid && !exe_dis) state_d = ST_FETCH;
         ST_FETCH: begin
            if (!cmd_valid)               state_d = ST_IDLE;
            else if (is_acq && !count_pos) state_d = ST_STALL;
            else begin
               cmd_ready = 1'b1;
               state_d   = ST_EXEC;
            end
         end
         ST_STALL: if (count_pos) state_d = ST_FETCH;
         ST_EXEC:  if (exec_done || wdog_expire) state_d = ST_FETCH;
         default: begin
            legal   = 1'b0;
            state_d = ST_IDLE;
            bad_d   = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bad_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         bad_q   <= bad_d;
      end
   end

   assign stalled   = (state_q == ST_STALL);
   assign exec_busy = (state_q == ST_EXEC);
   assign idle_st   = (state_q == ST_IDLE);
   assign bad_state = bad_q;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STALL && !count_pos) |=> (state_q == ST_STALL)); // R5
   AST_DIS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && exe_dis) |=> (state_q == ST_IDLE)); // R6
   AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !legal |=> bad_q); // R9
   AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXEC && !exec_done && !wdog_expire) |=> (state_q == ST_EXEC)); // R10
endmodule

// File: rtl/dbell_seq.sv
module dbell_seq #(
   parameter int              OP_W       = 8,
   parameter int              CNT_W      = 8,
   parameter int              WDOG_LIMIT = 16,
   parameter logic [OP_W-1:0] ACQ_OP     = 8'h5A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [OP_W-1:0]  cmd_op,
   output logic             cmd_ready,
   input  logic             exe_dis,
   input  logic             db_wr,
   input  logic [CNT_W-1:0] db_wdata,
   output logic [CNT_W-1:0] db_count,
   output logic             exec_start,
   output logic [OP_W-1:0]  exec_op,
   input  logic             exec_done,
   output logic             idle,
   output logic             stalled,
   output logic             wdog_expire,
   output logic             bad_state
);
   logic is_acq, take, spend, count_pos, exec_busy, idle_st;

   assign is_acq = (cmd_op == ACQ_OP);
   assign take   = cmd_valid && cmd_ready;
   assign spend  = take && is_acq;

   dbs_credit #(.CNT_W(CNT_W)) u_credit (
      .clk(clk), .rst_n(rst_n), .wr(db_wr), .wdata(db_wdata),
      .dec(spend), .count(db_count), .count_pos(count_pos)
   );

   dbs_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
      .clk(clk), .rst_n(rst_n), .busy(exec_busy), .done(exec_done),
      .expire(wdog_expire)
   );

   dbs_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .is_acq(is_acq),
      .count_pos(count_pos), .exe_dis(exe_dis), .exec_done(exec_done),
      .wdog_expire(wdog_expire), .cmd_ready(cmd_ready), .stalled(stalled),
      .exec_busy(exec_busy), .idle_st(idle_st), .bad_state(bad_state)
   );

   assign exec_start = take;
   assign exec_op    = cmd_op;
   assign idle       = idle_st && !cmd_valid;

   AST_ACQ_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      spend |-> (!db_count[CNT_W-1] && (|db_count))); // R4
   AST_WDOG_QUIET_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |-> !wdog_expire); // R8
   AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_expire |=> !wdog_expire); // R8
   AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!exec_busy && !stalled)); // R7
endmodule

// File: tb/test_dbell_seq.sv
module test_dbell_seq;
   localparam logic [7:0] ACQ  = 8'h5A;
   localparam int         WDOG = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_op = 8'h00;
   logic       cmd_ready;
   logic       exe_dis = 1'b0;
   logic       db_wr = 1'b0;
   logic [7:0] db_wdata = 8'h00;
   logic [7:0] db_count;
   logic       exec_start;
   logic [7:0] exec_op;
   logic       exec_done = 1'b0;
   logic       idle, stalled, wdog_expire, bad_state;

   int checks = 0;
   int errs   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dbell_seq #(.OP_W(8), .CNT_W(8), .WDOG_LIMIT(WDOG), .ACQ_OP(ACQ)) i_dbell_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_ready(cmd_ready), .exe_dis(exe_dis), .db_wr(db_wr),
      .db_wdata(db_wdata), .db_count(db_count), .exec_start(exec_start),
      .exec_op(exec_op), .exec_done(exec_done), .idle(idle),
      .stalled(stalled), .wdog_expire(wdog_expire), .bad_state(bad_state)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      db_wr = 1'b1; db_wdata = d;
      @(negedge clk);
      db_wr = 1'b0;
   endtask

   task automatic send(input logic [7:0] op, input int lat, input int maxw,
                       output bit ok);
      ok = 1'b0;
      cmd_valid = 1'b1; cmd_op = op;
      for (int i = 0; i < maxw; i++) begin
         #1;
         if (cmd_ready) begin ok = 1'b1; break; end
         @(negedge clk);
      end
      if (!ok) return;
      chk(exec_start && exec_op == op, "R10", "exec_start/op at take",
          int'(exec_op), int'(op));
      @(negedge clk);
      if (lat > 0) begin
         cmd_op = 8'hEE;
         for (int j = 0; j < lat; j++) begin
            #1;
            chk(!cmd_ready, "R10", "no take while executing", int'(cmd_ready), 0);
            @(negedge clk);
         end
      end
      cmd_valid = 1'b0; exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(db_count == 8'h00, "R1", "count after reset", int'(db_count), 0);
      chk(idle && !stalled && !wdog_expire && !bad_state, "R1", "status after reset",
          {idle, stalled, wdog_expire, bad_state}, 4'b1000);
   endtask

   task automatic t_writes;
      do_write(8'd5);
      chk(db_count == 8'd5, "R2", "add +5", int'(db_count), 5);
      do_write(8'hFD);
      chk(db_count == 8'd2, "R2", "add -3", int'(db_count), 2);
      do_write(8'h7F);
      do_write(8'h7F);
      chk(db_count == 8'h00, "R2", "wrap modulo 256", int'(db_count), 0);
      @(negedge clk);
      chk(db_count == 8'h00, "R2", "hold without write", int'(db_count), 0);
   endtask

   task automatic t_nonacq;
      bit ok;
      send(8'h10, 2, 4, ok);
      chk(ok, "R4", "non-acquire taken at zero credit", int'(ok), 1);
      chk(db_count == 8'h00, "R4", "non-acquire spends no credit", int'(db_count), 0);
      @(negedge clk);
      chk(idle, "R7", "idle after drain", int'(idle), 1);
   endtask

   task automatic t_acq;
      bit ok;
      do_write(8'd3);
      send(ACQ, 1, 4, ok);
      chk(ok, "R3", "acquire taken with credit", int'(ok), 1);
      chk(db_count == 8'd2, "R3", "acquire spends one", int'(db_count), 2);
      @(negedge clk);
   endtask

   task automatic t_stall;
      bit ok;
      bit bad;
      do_write(8'hFE);
      send(ACQ, 0, 4, ok);
      chk(!ok && stalled, "R4", "acquire stalls at zero", int'(stalled), 1);
      bad = 1'b0;
      for (int k = 0; k < 3 * WDOG; k++) begin
         #1;
         if (!stalled || wdog_expire || cmd_ready) bad = 1'b1;
         @(negedge clk);
      end
      chk(!bad, "R8", "no watchdog while stalled", int'(bad), 0);
      do_write(8'hFF);
      @(negedge clk);
      chk(stalled && db_count == 8'hFF, "R5", "stall holds at -1", int'(db_count), 255);
      do_write(8'h01);
      @(negedge clk);
      chk(stalled, "R5", "stall holds at 0", int'(stalled), 1);
      do_write(8'h02);
      send(ACQ, 1, 6, ok);
      chk(ok, "R5", "held acquire taken once positive", int'(ok), 1);
      chk(db_count == 8'd1, "R5", "count after release", int'(db_count), 1);
      @(negedge clk);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = ACQ;
      @(negedge clk);
      #1;
      chk(cmd_ready, "R3", "acquire ready", int'(cmd_ready), 1);
      db_wr = 1'b1; db_wdata = 8'd5;
      @(negedge clk);
      db_wr = 1'b0; cmd_valid = 1'b0;
      chk(db_count == 8'd5, "R3", "write and spend together", int'(db_count), 5);
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_exe_dis;
      bit ok;
      exe_dis = 1'b1;
      send(8'h20, 0, 5, ok);
      chk(!ok, "R6", "no start while disabled", int'(ok), 0);
      chk(!idle, "R7", "idle low with queued command", int'(idle), 0);
      exe_dis = 1'b0;
      send(8'h20, 0, 4, ok);
      chk(ok, "R6", "resume after enable", int'(ok), 1);
      exe_dis = 1'b1;
      send(8'h21, 1, 4, ok);
      chk(ok, "R6", "running sequence continues", int'(ok), 1);
      @(negedge clk);
      @(negedge clk);
      send(8'h22, 0, 5, ok);
      chk(!ok, "R6", "no restart after drain", int'(ok), 0);
      exe_dis = 1'b0;
      send(8'h22, 0, 4, ok);
      chk(ok, "R6", "restart after enable", int'(ok), 1);
      @(negedge clk);
   endtask

   task automatic t_wdog;
      int first = -1;
      int pulses = 0;
      cmd_valid = 1'b1; cmd_op = 8'h30;
      @(negedge clk);
      #1;
      chk(cmd_ready, "R10", "ready for watchdog command", int'(cmd_ready), 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 1; k <= 2 * WDOG; k++) begin
         #1;
         if (wdog_expire) begin
            pulses++;
            if (first < 0) first = k;
         end
         @(negedge clk);
      end
      chk(first == WDOG, "R8", "watchdog cycle", first, WDOG);
      chk(pulses == 1, "R8", "single watchdog pulse", pulses, 1);
      chk(idle, "R8", "abandoned command frees sequencer", int'(idle), 1);
   endtask

   task automatic t_bad;
      chk(!bad_state, "R9", "no bad state before fault", int'(bad_state), 0);
      force i_dbell_seq.u_fsm.state_q = dbs_pkg::seq_state_e'(3'd6);
      @(negedge clk);
      release i_dbell_seq.u_fsm.state_q;
      @(negedge clk);
      chk(bad_state, "R9", "bad flag set", int'(bad_state), 1);
      chk(idle, "R9", "recovered to idle", int'(idle), 1);
   endtask

   initial begin
      t_reset();
      t_writes();
      t_nonacq();
      t_acq();
      t_stall();
      t_same_cycle();
      t_exe_dis();
      t_wdog();
      t_bad();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         checks++;
         errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule